// File: doc/BRIEF.md
# FMA Align-Add-Normalize Datapath

This block is the arithmetic core that sits behind a double-precision multiplier in a fused multiply-add unit. It takes the raw wide product of two 53-bit significands, together with the product's exponent and the signs of the two factors, plus the 53-bit addend significand with its own exponent and sign. It lines the two operands up on a common exponent, adds or subtracts them at full width, renormalizes the result and narrows it to a 56-bit significand: 53 bits plus guard, round and sticky. No bit of the product is dropped before the add, so the unit rounding downstream sees a single-rounding result.

The inputs must be finite and nonzero. Packing, special values and the final rounding belong to neighbouring blocks. A negate input selects the multiply-subtract variant. A round-toward-minus-infinity input sets the sign of an exact-zero difference. The datapath is pipelined over three register stages, with a valid bit that travels alongside the data. A new operation can be issued on every cycle.

Top module: `fma_sum_core`

## Requirements
- R1: valid_o is asserted exactly three rising clock edges after valid_i is sampled high. Back-to-back inputs produce back-to-back results in issue order, and valid_o stays low at reset and when no input was issued.
- R2: The product sign is x_sign_i XOR y_sign_i XOR negate_i (negate_i=1 selects multiply-subtract).
- R3: If bit 127 of prod_man_i is set, the product is shifted right by one, the shifted-out bit is ORed into bit 0 and the product exponent is incremented. Otherwise the leading 1 is taken to be at bit 126.
- R4: The addend significand (leading 1 at bit 52) is placed with its leading 1 at bit 126 of the 128-bit working value, with zeros below.
- R5: The operand with the smaller exponent is shifted right by the exponent difference, and every bit shifted out is ORed into bit 0 (sticky). A shift of 127 or more leaves only that sticky bit. The common exponent is the larger exponent.
- R6: When the addend sign equals the product sign, the aligned values are added. A carry into bit 127 causes a 1-bit sticky right shift and an exponent increment, and the result sign is the product sign.
- R7: When the signs differ, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger one, and the addend's sign when the addend magnitude is greater than or equal to the product's.
- R8: An exact-zero difference gives zero_o=1, man_o=0, exp_o=0, and sign_o equal to rnd_down_i.
- R9: A nonzero result is shifted left until its leading 1 is at bit 126, and the exponent is reduced by the shift amount. man_o[55] is therefore 1 for every nonzero result.
- R10: man_o holds bits 126..71 of the normalized value, with the OR of bits 70..0 ORed into man_o[0]. This is a sticky right shift by 71.
- R11: Exponents are two's complement. exp_o is two bits wider than the input exponents, so results below the normal range (for example under -2000) are carried without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand set present this cycle |
| prod_man_i | input | 128 | Raw product of the two significands, leading 1 at bit 127 or 126 |
| prod_exp_i | input | 13 | Unbiased product exponent, signed |
| x_sign_i | input | 1 | Sign of first factor |
| y_sign_i | input | 1 | Sign of second factor |
| negate_i | input | 1 | Negate the product (multiply-subtract) |
| add_man_i | input | 53 | Addend significand, leading 1 at bit 52 |
| add_exp_i | input | 13 | Unbiased addend exponent, signed |
| add_sign_i | input | 1 | Addend sign |
| rnd_down_i | input | 1 | Rounding mode is toward minus infinity |
| valid_o | output | 1 | Result present |
| sign_o | output | 1 | Result sign |
| exp_o | output | 15 | Result exponent, signed |
| man_o | output | 56 | Result significand with guard, round and sticky bits |
| zero_o | output | 1 | Result is exactly zero |

## Verification
Assertions check the following on every cycle:
- the larger aligned operand carries its leading 1 at bit 126;
- an effective addition always leaves its leading 1 at bit 126 once the carry is handled;
- a staged result always reaches the output one cycle later;
- every nonzero output has man_o[55] set;
- a zero output has a cleared significand and exponent.

Only the bench's scenarios with computed expected values can show the rest:
- correct sign choice under negation and under subtraction;
- sticky behaviour for alignment shifts both moderate and beyond the working width;
- deep cancellation with large left shifts;
- the rounding-mode dependent sign of an exact zero;
- exponents far below the normal range.

// File: rtl/fma_sum_pkg.sv
package fma_sum_pkg;

  typedef enum logic {
    EFF_ADD = 1'b0,
    EFF_SUB = 1'b1
  } eff_op_e;

  function automatic logic prod_sign(input logic xs, input logic ys, input logic neg);
    return xs ^ ys ^ neg;
  endfunction

endpackage

// File: rtl/fma_sticky_shr.sv
module fma_sticky_shr #(
  parameter int W     = 127,
  parameter int CNT_W = 15
) (
  input  logic [W-1:0]     din_i,
  input  logic [CNT_W-1:0] amt_i,
  output logic [W-1:0]     dout_o
);

  logic lost;

  always_comb begin
    lost   = 1'b0;
    dout_o = '0;
    if (32'(amt_i) >= W) begin
      dout_o[0] = |din_i;
    end else begin
      lost      = |(din_i & ~({W{1'b1}} << amt_i));
      dout_o    = din_i >> amt_i;
      dout_o[0] = dout_o[0] | lost;
    end
  end

endmodule

// File: rtl/fma_lzc.sv
module fma_lzc #(
  parameter int W  = 127,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din_i,
  output logic [CW-1:0] cnt_o
);

  // Ascending scan: the highest set bit is the last one to write.
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/fma_sum_core.sv
module fma_sum_core
  import fma_sum_pkg::*;
#(
  parameter int MAN_W  = 53,
  parameter int WIDE_W = 128,
  parameter int EXP_W  = 13,
  parameter int GRS_W  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [WIDE_W-1:0]             prod_man_i,
  input  logic signed [EXP_W-1:0]       prod_exp_i,
  input  logic                          x_sign_i,
  input  logic                          y_sign_i,
  input  logic                          negate_i,
  input  logic [MAN_W-1:0]              add_man_i,
  input  logic signed [EXP_W-1:0]       add_exp_i,
  input  logic                          add_sign_i,
  input  logic                          rnd_down_i,
  output logic                          valid_o,
  output logic                          sign_o,
  output logic signed [EXP_W+1:0]       exp_o,
  output logic [MAN_W+GRS_W-1:0]        man_o,
  output logic                          zero_o
);

  localparam int HW     = WIDE_W - 1;          // held width, bit 127 always clear
  localparam int OUT_W  = MAN_W + GRS_W;
  localparam int PAD    = HW - MAN_W;
  localparam int NARROW = HW - OUT_W;
  localparam int XW     = 2;
  localparam int IEXP_W = EXP_W + XW;
  localparam int LZ_W   = $clog2(HW + 1);
  localparam logic signed [IEXP_W-1:0] EXP_ONE = IEXP_W'(1);

  // ---------------- stage 0: product fixup and alignment ----------------
  logic                     p_carry;
  logic [HW-1:0]            p_norm, a_wide, sh_in, sh_out;
  logic signed [IEXP_W-1:0] pe_ext, ae_ext, gap;
  logic                     add_dom;

  assign p_carry = prod_man_i[WIDE_W-1];
  assign p_norm  = p_carry ? (prod_man_i[WIDE_W-1:1] | {{(HW-1){1'b0}}, prod_man_i[0]})
                           : prod_man_i[HW-1:0];
  assign pe_ext  = {{XW{prod_exp_i[EXP_W-1]}}, prod_exp_i} + (p_carry ? EXP_ONE : '0);
  assign ae_ext  = {{XW{add_exp_i[EXP_W-1]}}, add_exp_i};
  assign a_wide  = {add_man_i, {PAD{1'b0}}};
  assign add_dom = ae_ext > pe_ext;
  assign gap     = add_dom ? (ae_ext - pe_ext) : (pe_ext - ae_ext);
  assign sh_in   = add_dom ? p_norm : a_wide;

  fma_sticky_shr #(.W(HW), .CNT_W(IEXP_W)) u_align (
    .din_i (sh_in),
    .amt_i (gap),
    .dout_o(sh_out)
  );

  logic                     s1_v_q, s1_a_sign_q, s1_p_sign_q, s1_rd_q, s1_dom_q;
  logic [HW-1:0]            s1_a_q, s1_p_q;
  logic signed [IEXP_W-1:0] s1_exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q      <= 1'b0;
      s1_a_q      <= '0;
      s1_p_q      <= '0;
      s1_exp_q    <= '0;
      s1_a_sign_q <= 1'b0;
      s1_p_sign_q <= 1'b0;
      s1_rd_q     <= 1'b0;
      s1_dom_q    <= 1'b0;
    end else begin
      s1_v_q <= valid_i;
      if (valid_i) begin
        s1_a_q      <= add_dom ? a_wide : sh_out;
        s1_p_q      <= add_dom ? sh_out : p_norm;
        s1_exp_q    <= add_dom ? ae_ext : pe_ext;
        s1_a_sign_q <= add_sign_i;
        s1_p_sign_q <= prod_sign(x_sign_i, y_sign_i, negate_i);
        s1_rd_q     <= rnd_down_i;
        s1_dom_q    <= add_dom;
      end
    end
  end

  a_r5_larger_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v_q |-> (s1_dom_q ? s1_a_q[HW-1] : s1_p_q[HW-1]));

  // ---------------- stage 1: add or subtract ----------------
  eff_op_e                  eff_op;
  logic [WIDE_W-1:0]        sum_w;
  logic [HW-1:0]            diff, res_d;
  logic                     a_ge, sign_d, zero_d;
  logic signed [IEXP_W-1:0] exp_d;

  assign eff_op = (s1_a_sign_q ^ s1_p_sign_q) ? EFF_SUB : EFF_ADD;
  assign sum_w  = {1'b0, s1_a_q} + {1'b0, s1_p_q};
  assign a_ge   = s1_a_q >= s1_p_q;
  assign diff   = a_ge ? (s1_a_q - s1_p_q) : (s1_p_q - s1_a_q);

  always_comb begin
    res_d  = diff;
    exp_d  = s1_exp_q;
    sign_d = s1_p_sign_q;
    zero_d = 1'b0;
    if (eff_op == EFF_ADD) begin
      if (sum_w[WIDE_W-1]) begin
        res_d = sum_w[WIDE_W-1:1] | {{(HW-1){1'b0}}, sum_w[0]};
        exp_d = s1_exp_q + EXP_ONE;
      end else begin
        res_d = sum_w[HW-1:0];
      end
    end else begin
      sign_d = a_ge ? s1_a_sign_q : s1_p_sign_q;
      zero_d = (diff == '0);
      if (zero_d) sign_d = s1_rd_q;
    end
  end

  logic                     s2_v_q, s2_sign_q, s2_zero_q;
  eff_op_e                  s2_op_q;
  logic [HW-1:0]            s2_res_q;
  logic signed [IEXP_W-1:0] s2_exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v_q    <= 1'b0;
      s2_res_q  <= '0;
      s2_exp_q  <= '0;
      s2_sign_q <= 1'b0;
      s2_zero_q <= 1'b0;
      s2_op_q   <= EFF_ADD;
    end else begin
      s2_v_q <= s1_v_q;
      if (s1_v_q) begin
        s2_res_q  <= res_d;
        s2_exp_q  <= exp_d;
        s2_sign_q <= sign_d;
        s2_zero_q <= zero_d;
        s2_op_q   <= eff_op;
      end
    end
  end

  a_r6_sum_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_v_q && s2_op_q == EFF_ADD) |-> s2_res_q[HW-1]);

  // ---------------- stage 2: normalize and narrow ----------------
  logic [LZ_W-1:0]          lz;
  logic signed [IEXP_W-1:0] lz_s, exp_n;
  logic [HW-1:0]            norm;
  logic [OUT_W-1:0]         man_n;

  fma_lzc #(.W(HW), .CW(LZ_W)) u_lzc (
    .din_i(s2_res_q),
    .cnt_o(lz)
  );

  assign lz_s  = IEXP_W'(lz);
  assign norm  = s2_res_q << lz;
  assign exp_n = s2_exp_q - lz_s;
  assign man_n = {norm[HW-1 -: OUT_W-1], norm[NARROW] | (|norm[NARROW-1:0])};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      exp_o   <= '0;
      man_o   <= '0;
      zero_o  <= 1'b0;
    end else begin
      valid_o <= s2_v_q;
      if (s2_v_q) begin
        sign_o <= s2_sign_q;
        zero_o <= s2_zero_q;
        man_o  <= s2_zero_q ? '0 : man_n;
        exp_o  <= s2_zero_q ? '0 : exp_n;
      end
    end
  end

  a_r1_flow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_v_q |=> valid_o);

  a_r9_lead_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !zero_o) |-> man_o[OUT_W-1]);

  a_r8_zero_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zero_o) |-> (man_o == '0 && exp_o == '0));

endmodule

// File: tb/fma_sum_core_bench.sv
`timescale 1ns/1ps
module fma_sum_core_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                valid_i = 1'b0;
  logic [127:0]        prod_man = '0;
  logic signed [12:0]  prod_exp = '0;
  logic                xs = 1'b0, ys = 1'b0, neg = 1'b0;
  logic [52:0]         add_man = '0;
  logic signed [12:0]  add_exp = '0;
  logic                add_sign = 1'b0, rd = 1'b0;
  logic                valid_o, sign_o, zero_o;
  logic signed [14:0]  exp_o;
  logic [55:0]         man_o;

  fma_sum_core u_fma_sum_core (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .prod_man_i(prod_man), .prod_exp_i(prod_exp),
    .x_sign_i(xs), .y_sign_i(ys), .negate_i(neg),
    .add_man_i(add_man), .add_exp_i(add_exp), .add_sign_i(add_sign),
    .rnd_down_i(rd),
    .valid_o(valid_o), .sign_o(sign_o), .exp_o(exp_o), .man_o(man_o), .zero_o(zero_o)
  );

  typedef struct packed {
    logic               s;
    logic signed [14:0] e;
    logic [55:0]        m;
    logic               z;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  function automatic logic [127:0] ref_shr(input logic [127:0] v, input int n);
    logic st;
    st = 1'b0;
    for (int i = 0; i < n && i < 130; i++) begin
      st = st | v[0];
      v  = v >> 1;
    end
    v[0] = v[0] | st;
    return v;
  endfunction

  function automatic logic [127:0] mk_prod(input logic [52:0] mx, input logic [52:0] my);
    logic [127:0] a, b;
    a = 128'(mx) << 11;
    b = 128'(my) << 11;
    return a * b;
  endfunction

  function automatic res_t ref_model(input logic [127:0] prod, input int pe,
                                     input logic sx, input logic sy, input logic ng,
                                     input logic [52:0] am, input int ae,
                                     input logic sa, input logic rdn);
    res_t r;
    logic ps;
    logic [127:0] p, a, s;
    int e;
    r  = '0;
    ps = sx ^ sy ^ ng;
    p  = prod;
    if (p[127]) begin p = ref_shr(p, 1); pe++; end
    a = {1'b0, am, 74'b0};
    if (ae > pe) begin p = ref_shr(p, ae - pe); e = ae; end
    else begin a = ref_shr(a, pe - ae); e = pe; end
    if (ps == sa) begin
      s = a + p; r.s = ps;
      if (s[127]) begin s = ref_shr(s, 1); e++; end
    end else begin
      if (a >= p) begin s = a - p; r.s = sa; end
      else begin s = p - a; r.s = ps; end
      if (s == 0) begin r.z = 1'b1; r.s = rdn; return r; end
    end
    while (!s[126]) begin s = s << 1; e--; end
    s   = ref_shr(s, 71);
    r.m = s[55:0];
    r.e = 15'(e);
    return r;
  endfunction

  task automatic drive(input string tag, input logic [127:0] prod, input int pe,
                       input logic sx, input logic sy, input logic ng,
                       input logic [52:0] am, input int ae, input logic sa, input logic rdn);
    @(negedge clk);
    valid_i  = 1'b1;
    prod_man = prod;  prod_exp = 13'(pe);
    xs = sx; ys = sy; neg = ng;
    add_man = am;     add_exp = 13'(ae);
    add_sign = sa;    rd = rdn;
    exp_q.push_back(ref_model(prod, pe, sx, sy, ng, am, ae, sa, rdn));
    tag_q.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && valid_o) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1 unexpected valid_o: got 1 expected 0");
      end else begin
        res_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (sign_o !== e.s || exp_o !== e.e || man_o !== e.m || zero_o !== e.z) begin
          n_bad++;
          $display("FAIL %s: got s=%0b e=%0d m=%h z=%0b expected s=%0b e=%0d m=%h z=%0b",
                   t, sign_o, exp_o, man_o, zero_o, e.s, e.e, e.m, e.z);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: got hang expected completion");
    finish_run();
  end

  localparam logic [52:0] ONE  = 53'h10_0000_0000_0000;
  localparam logic [52:0] MAXM = 53'h1F_FFFF_FFFF_FFFF;

  initial begin
    logic [63:0] st;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (valid_o !== 1'b0 || man_o !== '0) begin
      n_bad++;
      $display("FAIL R1 reset state: got v=%0b m=%h expected v=0 m=0", valid_o, man_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 carry into bit 127: 1*1 + 1 -> 2
    drive("R6 carry add", mk_prod(ONE, ONE), 0, 0, 0, 0, ONE, 0, 0, 0);
    // R2 negate flips product sign
    drive("R2 negate sign", mk_prod(ONE, ONE + 53'd5), 3, 1, 0, 1, ONE + 53'd9, 1, 0, 0);
    drive("R2 plain sign", mk_prod(ONE, ONE + 53'd5), 3, 1, 0, 0, ONE + 53'd9, 1, 1, 0);
    // R3 product with bit 127 set
    drive("R3 product carry", mk_prod(MAXM, MAXM), 10, 0, 0, 0, MAXM, 2, 0, 0);
    // R4 addend placement, product tiny
    drive("R4 addend place", mk_prod(ONE + 53'd3, ONE), -60, 0, 1, 0, ONE + 53'd77, 0, 1, 0);
    // R8 exact zero, both rounding modes
    drive("R8 zero rd0", mk_prod(ONE, ONE), 0, 0, 0, 0, ONE, 0, 1, 0);
    drive("R8 zero rd1", mk_prod(ONE, ONE), 0, 0, 0, 0, ONE, 0, 1, 1);
    // R5 shift beyond working width both ways
    drive("R5 far addend", mk_prod(MAXM, ONE + 53'd1), 0, 0, 0, 0, ONE, 400, 1, 0);
    drive("R5 far product", mk_prod(MAXM, ONE + 53'd1), 400, 0, 0, 0, ONE + 53'd1, -3, 1, 0);
    // R7 product larger and addend larger
    drive("R7 product larger", mk_prod(MAXM, MAXM), 0, 0, 0, 0, ONE, 0, 1, 0);
    drive("R7 addend larger", mk_prod(ONE, ONE + 53'd7), 0, 1, 0, 0, MAXM, 0, 0, 0);
    // R9 deep cancellation, R11 far below normal range
    drive("R9 cancel", mk_prod(ONE + 53'd1, ONE + 53'd1), 0, 0, 0, 0, ONE + 53'd2, 0, 1, 0);
    drive("R11 low exponent", mk_prod(ONE + 53'd1, ONE + 53'd1), -2000, 0, 0, 0, ONE + 53'd2, -2000, 1, 0);
    // R10 sticky into low bit
    drive("R10 sticky", mk_prod(MAXM, ONE + 53'd3), 0, 0, 0, 0, ONE + 53'd1, 50, 0, 0);

    st = 64'h1234_5678_9ABC_DEF1;
    for (int k = 0; k < 40; k++) begin
      logic [52:0] mx, my, am;
      int pe, ae;
      st = st * 64'd6364136223846793005 + 64'd1442695040888963407;
      mx = {1'b1, st[51:0]};
      st = st * 64'd6364136223846793005 + 64'd1442695040888963407;
      my = {1'b1, st[63:12]};
      st = st * 64'd6364136223846793005 + 64'd1442695040888963407;
      am = {1'b1, st[51:0]};
      pe = int'(st[61:56]) - 32;
      ae = pe + int'(st[55:52]) - 8;
      drive("R7 R6 random", mk_prod(mx, my), pe, st[63], st[62], k[0], am, ae, st[53], k[1]);
    end

    @(negedge clk);
    valid_i = 1'b0;
    repeat (8) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 missing results: got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule